// File: doc/BRIEF.md
# Self-ID Sequence Parser

This block sits behind the receiver of a serial bus PHY and turns a stream of 32-bit self-ID quadlets into one record per node. Quadlets arrive one per valid/ready handshake, and a last flag marks the final quadlet of the stream. A node's record spans one to four quadlets. The more flag in bit 0 links each quadlet to the next one. Every quadlet after the first is a continuation, and each continuation must carry an extended marker and a running sequence number.

When a node's chain closes, the parser presents the node's header fields, the number of quadlets the record used, and a flat vector of 2-bit port status codes. The output is held until it is accepted. If a chain is malformed, the parser pulses a fault output with a cause code. It then ignores the rest of the stream up to the last flag and starts again with a fresh first quadlet.

Top module: `selfid_parser`

## Requirements
- R1: After synchronous reset, `out_valid` and `fault_valid` are low and `in_ready` is high.
- R2: A record's header comes from its first quadlet: phy ID from bits 29:24, link active from bit 22, gap count from bits 21:16, speed code from bits 15:14, contender from bit 11, power class from bits 10:8 and initiated reset from bit 1. These appear on the outputs one cycle after the closing quadlet is accepted.
- R3: A record closes at the first accepted quadlet whose bit 0 is 0. `out_valid` rises in the next cycle, and `out_quad_count` gives the number of quadlets in the record (1 to 4).
- R4: If a continuation quadlet has bit 23 clear, the record is dropped and a fault with code 2 is reported.
- R5: Continuation k (k = 0, 1, 2) must carry k in bits 22:20. Any other value gives fault code 3.
- R6: If bit 0 is still set on the fourth quadlet of a record, fault code 4 is reported.
- R7: If the quadlet with the last flag has bit 0 set while the record is still under the limit, fault code 5 is reported. A fault pulses `fault_valid` for one cycle, one cycle after the offending quadlet is accepted.
- R8: Every quadlet must carry 2 in bits 31:30. Any other value gives fault code 1.
- R9: Port p (0 to 26) is reported in `out_port_codes[2p+1:2p]`. Its code is taken from quadlet (p+5)/8 of the record, at bits s+1:s, where s = 16 - 2*((p+5) mod 8). A port whose quadlet lies beyond the record reads 0. Codes are 0 absent, 1 unconnected, 2 parent, 3 child.
- R10: After a fault, accepted quadlets produce neither records nor faults up to and including the next quadlet with the last flag. If the faulting quadlet carried the last flag itself, the next quadlet is treated as a first quadlet.
- R11: While `out_valid` is high and `out_ready` is low, the record outputs hold their values and `in_ready` is low. In any other cycle `in_ready` is high.
- R12: When a quadlet breaks several rules, the reported code follows the priority 1, then 2, then 3, then 4, then 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Quadlet offered |
| in_ready | output | 1 | Quadlet can be taken |
| in_quad | input | 32 | Self-ID quadlet |
| in_last | input | 1 | Last quadlet of the stream |
| out_valid | output | 1 | Record presented |
| out_ready | input | 1 | Record accepted |
| out_phy_id | output | 6 | Node physical ID |
| out_link_active | output | 1 | Link active flag |
| out_gap_count | output | 6 | Gap count |
| out_speed | output | 2 | Speed code |
| out_contender | output | 1 | Contender flag |
| out_power_class | output | 3 | Power class |
| out_init_reset | output | 1 | Initiated-reset flag |
| out_quad_count | output | 3 | Quadlets in the record |
| out_port_codes | output | 54 | 27 port status codes, 2 bits each |
| fault_valid | output | 1 | Fault pulse |
| fault_code | output | 3 | Fault cause code |

## Verification
The bench targets several corner cases, and each one shows up as a specific wrong result:
- **Four-quadlet records.** An off-by-one in the length limit would either reject these records or let a fifth quadlet through.
- **A fourth quadlet that carries both the more flag and the last flag.** This checks the fault priority. A wrong order would report a truncation instead of an overlong record.
- **Discarded quadlets after a fault.** Some of these form well-shaped records. A parser that fails to discard would emit phantom records or a second fault.
- **Port fields that straddle quadlet boundaries, and ports past a short record.** A wrong offset would show up as shifted codes, and stale buffer contents as nonzero codes.
- **Output stalls.** A parser that drops or overwrites a held record, or takes input during a stall, would show a changed record or a missing one.

// File: rtl/selfid_pkg.sv
package selfid_pkg;

    localparam int QW          = 32;
    localparam int PORT_SKEW   = 5;
    localparam int PORTS_PER_Q = 8;
    localparam logic [1:0] SELF_TAG = 2'd2;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_TAG     = 3'd1,
        FLT_NO_EXT  = 3'd2,
        FLT_SEQNO   = 3'd3,
        FLT_OVERLEN = 3'd4,
        FLT_TRUNC   = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        PS_FIRST,
        PS_CONT,
        PS_DRAIN
    } pstate_e;

    typedef struct packed {
        logic [5:0] phy;
        logic       link;
        logic [5:0] gap;
        logic [1:0] speed;
        logic       contender;
        logic [2:0] power;
        logic       init_reset;
    } node_hdr_t;

    function automatic logic [1:0] q_tag(input logic [QW-1:0] q);
        return q[31:30];
    endfunction

    function automatic logic q_more(input logic [QW-1:0] q);
        return q[0];
    endfunction

    function automatic logic q_ext(input logic [QW-1:0] q);
        return q[23];
    endfunction

    function automatic logic [2:0] q_seqno(input logic [QW-1:0] q);
        return q[22:20];
    endfunction

    function automatic node_hdr_t hdr_decode(input logic [QW-1:0] q);
        node_hdr_t h;
        h.phy        = q[29:24];
        h.link       = q[22];
        h.gap        = q[21:16];
        h.speed      = q[15:14];
        h.contender  = q[11];
        h.power      = q[10:8];
        h.init_reset = q[1];
        return h;
    endfunction

    function automatic int port_quad(input int p);
        return (p + PORT_SKEW) / PORTS_PER_Q;
    endfunction

    function automatic int port_shift(input int p);
        return 16 - ((p + PORT_SKEW) % PORTS_PER_Q) * 2;
    endfunction

endpackage

// File: rtl/selfid_chain_check.sv
module selfid_chain_check
    import selfid_pkg::*;
#(
    parameter int MAX_QUADS = 4,
    localparam int IDX_W    = $clog2(MAX_QUADS)
) (
    input  logic [QW-1:0]    quad,
    input  logic             is_cont,
    input  logic [IDX_W-1:0] slot,
    input  logic             last,
    output fault_e           fault,
    output logic             closes
);
    logic [2:0] want_seq;

    assign want_seq = 3'(slot) - 3'd1;
    assign closes   = !q_more(quad);

    always_comb begin
        fault = FLT_NONE;
        if (q_tag(quad) != SELF_TAG)
            fault = FLT_TAG;
        else if (is_cont && !q_ext(quad))
            fault = FLT_NO_EXT;
        else if (is_cont && q_seqno(quad) != want_seq)
            fault = FLT_SEQNO;
        else if (q_more(quad) && slot == IDX_W'(MAX_QUADS - 1))
            fault = FLT_OVERLEN;
        else if (q_more(quad) && last)
            fault = FLT_TRUNC;
    end
endmodule

// File: rtl/selfid_port_unpack.sv
module selfid_port_unpack
    import selfid_pkg::*;
#(
    parameter int MAX_QUADS = 4,
    localparam int NPORTS   = MAX_QUADS * PORTS_PER_Q - PORT_SKEW,
    localparam int CNT_W    = $clog2(MAX_QUADS + 1)
) (
    input  logic [MAX_QUADS*QW-1:0] quads,
    input  logic [CNT_W-1:0]        count,
    output logic [2*NPORTS-1:0]     codes
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int QI = port_quad(p);
        localparam int SH = port_shift(p);
        assign codes[2*p +: 2] = (CNT_W'(QI) < count) ? quads[QI*QW + SH +: 2] : 2'b00;
    end
endmodule

// File: rtl/selfid_parser.sv
module selfid_parser
    import selfid_pkg::*;
#(
    parameter int MAX_QUADS = 4,
    localparam int IDX_W    = $clog2(MAX_QUADS),
    localparam int CNT_W    = $clog2(MAX_QUADS + 1),
    localparam int NPORTS   = MAX_QUADS * PORTS_PER_Q - PORT_SKEW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [31:0]         in_quad,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [5:0]          out_phy_id,
    output logic                out_link_active,
    output logic [5:0]          out_gap_count,
    output logic [1:0]          out_speed,
    output logic                out_contender,
    output logic [2:0]          out_power_class,
    output logic                out_init_reset,
    output logic [CNT_W-1:0]    out_quad_count,
    output logic [2*NPORTS-1:0] out_port_codes,
    output logic                fault_valid,
    output logic [2:0]          fault_code
);
    pstate_e              state;
    logic [IDX_W-1:0]     slot;
    logic [QW-1:0]        qbuf [MAX_QUADS];
    logic [MAX_QUADS*QW-1:0] gathered;
    logic                 take;
    fault_e               fault_now;
    fault_e               fault_q;
    logic                 closes;
    logic [CNT_W-1:0]     count_now;
    logic [2*NPORTS-1:0]  codes_now;
    node_hdr_t            hdr_now;
    node_hdr_t            hdr_q;

    assign in_ready  = !out_valid || out_ready;
    assign take      = in_valid && in_ready;
    assign count_now = CNT_W'(slot) + CNT_W'(1);

    for (genvar i = 0; i < MAX_QUADS; i++) begin : g_gather
        assign gathered[i*QW +: QW] = (IDX_W'(i) == slot) ? in_quad : qbuf[i];
    end

    assign hdr_now = hdr_decode(gathered[QW-1:0]);

    selfid_chain_check #(.MAX_QUADS(MAX_QUADS)) u_check (
        .quad    (in_quad),
        .is_cont (state == PS_CONT),
        .slot    (slot),
        .last    (in_last),
        .fault   (fault_now),
        .closes  (closes)
    );

    selfid_port_unpack #(.MAX_QUADS(MAX_QUADS)) u_unpack (
        .quads (gathered),
        .count (count_now),
        .codes (codes_now)
    );

    always_ff @(posedge clk) begin
        if (take && state != PS_DRAIN && fault_now == FLT_NONE && !closes)
            qbuf[slot] <= in_quad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= PS_FIRST;
            slot           <= '0;
            out_valid      <= 1'b0;
            fault_valid    <= 1'b0;
            fault_q        <= FLT_NONE;
            hdr_q          <= '0;
            out_quad_count <= '0;
            out_port_codes <= '0;
        end else begin
            fault_valid <= 1'b0;
            if (out_valid && out_ready)
                out_valid <= 1'b0;
            if (take) begin
                if (state == PS_DRAIN) begin
                    if (in_last)
                        state <= PS_FIRST;
                end else if (fault_now != FLT_NONE) begin
                    fault_valid <= 1'b1;
                    fault_q     <= fault_now;
                    slot        <= '0;
                    state       <= in_last ? PS_FIRST : PS_DRAIN;
                end else if (closes) begin
                    out_valid      <= 1'b1;
                    hdr_q          <= hdr_now;
                    out_quad_count <= count_now;
                    out_port_codes <= codes_now;
                    slot           <= '0;
                    state          <= PS_FIRST;
                end else begin
                    slot  <= slot + IDX_W'(1);
                    state <= PS_CONT;
                end
            end
        end
    end

    assign out_phy_id      = hdr_q.phy;
    assign out_link_active = hdr_q.link;
    assign out_gap_count   = hdr_q.gap;
    assign out_speed       = hdr_q.speed;
    assign out_contender   = hdr_q.contender;
    assign out_power_class = hdr_q.power;
    assign out_init_reset  = hdr_q.init_reset;
    assign fault_code      = fault_q;
endmodule

// File: rtl/selfid_parser_sva.sv
module selfid_parser_sva #(
    parameter int MAX_QUADS = 4,
    localparam int CNT_W    = $clog2(MAX_QUADS + 1),
    localparam int NPORTS   = MAX_QUADS * 8 - 5
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [31:0]         in_quad,
    input logic                out_valid,
    input logic                out_ready,
    input logic [5:0]          out_phy_id,
    input logic [CNT_W-1:0]    out_quad_count,
    input logic [2*NPORTS-1:0] out_port_codes,
    input logic                fault_valid,
    input logic [2:0]          fault_code
);
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_port_codes)
            && $stable(out_phy_id) && $stable(out_quad_count));

    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_quad_count >= CNT_W'(1) && out_quad_count <= CNT_W'(MAX_QUADS));

    assert_new_record_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready && !in_quad[0]));

    assert_record_tag_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_quad[31:30]) == 2'd2);

    assert_short_ports_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_quad_count == CNT_W'(1) |-> out_port_codes[2*NPORTS-1:6] == '0);

    assert_fault_code_R7: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> fault_code >= 3'd1 && fault_code <= 3'd5);

    assert_fault_source_R10: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> $past(in_valid && in_ready));
endmodule

bind selfid_parser selfid_parser_sva #(.MAX_QUADS(MAX_QUADS)) u_sva (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_quad        (in_quad),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_phy_id     (out_phy_id),
    .out_quad_count (out_quad_count),
    .out_port_codes (out_port_codes),
    .fault_valid    (fault_valid),
    .fault_code     (fault_code)
);

// File: tb/sim_selfid_parser.sv
`timescale 1ns/1ps
module sim_selfid_parser;
    localparam int NP = 27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [31:0] in_quad = '0;
    logic in_last = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid, out_link_active, out_contender, out_init_reset;
    logic [5:0] out_phy_id, out_gap_count;
    logic [1:0] out_speed;
    logic [2:0] out_power_class, out_quad_count, fault_code;
    logic [2*NP-1:0] out_port_codes;
    logic fault_valid;

    always #10 clk = ~clk;

    selfid_parser u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_quad(in_quad), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_phy_id(out_phy_id),
        .out_link_active(out_link_active), .out_gap_count(out_gap_count),
        .out_speed(out_speed), .out_contender(out_contender),
        .out_power_class(out_power_class), .out_init_reset(out_init_reset),
        .out_quad_count(out_quad_count), .out_port_codes(out_port_codes),
        .fault_valid(fault_valid), .fault_code(fault_code)
    );

    int n_checks = 0;
    int n_fail = 0;
    string scen = "R1";
    bit stall_mode = 1'b0;
    int cyc = 0;

    // reference model state
    bit m_ov, m_fv;
    int m_fc, m_mode, m_cnt;
    logic [31:0] m_first;
    logic [2*NP-1:0] m_ports;
    logic [31:0] mq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s) %s actual=%0h expected=%0h", req, scen, what, act, exp);
        end
    endtask

    function automatic string code_req(input int c);
        case (c)
            1: return "R8";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(negedge clk) begin
        cyc <= cyc + 1;
        out_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;
    end

    always @(posedge clk) begin
        int n, qi, sh, e;
        logic [31:0] d;
        logic [2*NP-1:0] pv;
        if (rst) begin
            m_ov <= 0; m_fv <= 0; m_fc <= 0; m_mode = 0; mq.delete();
        end else begin
            m_fv <= 0;
            if (m_ov && out_ready) m_ov <= 0;
            if (in_valid && (!m_ov || out_ready)) begin
                if (m_mode == 2) begin
                    if (in_last) m_mode = 0;
                end else begin
                    mq.push_back(in_quad);
                    n = mq.size();
                    d = in_quad;
                    e = 0;
                    if (d[31:30] != 2) e = 1;
                    else if (n > 1 && !d[23]) e = 2;
                    else if (n > 1 && int'(d[22:20]) != n - 2) e = 3;
                    else if (d[0] && n == 4) e = 4;
                    else if (d[0] && in_last) e = 5;
                    if (e != 0) begin
                        m_fv <= 1; m_fc <= e; mq.delete();
                        m_mode = in_last ? 0 : 2;
                    end else if (!d[0]) begin
                        for (int p = 0; p < NP; p++) begin
                            qi = (p + 5) / 8;
                            sh = 16 - ((p + 5) % 8) * 2;
                            pv[2*p +: 2] = (qi < n) ? mq[qi][sh +: 2] : 2'b00;
                        end
                        m_ov <= 1; m_first <= mq[0]; m_cnt <= n; m_ports <= pv;
                        mq.delete();
                        m_mode = 0;
                    end else begin
                        m_mode = 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        #5;
        if (!rst) begin
            chk(in_ready == (!m_ov || out_ready), "R11", "in_ready", 64'(in_ready), 64'(!m_ov || out_ready));
            chk(out_valid == m_ov, "R3", "out_valid", 64'(out_valid), 64'(m_ov));
            if (m_ov && out_valid) begin
                chk({out_phy_id, out_link_active, out_gap_count, out_speed, out_contender,
                     out_power_class, out_init_reset} ==
                    {m_first[29:24], m_first[22], m_first[21:16], m_first[15:14], m_first[11],
                     m_first[10:8], m_first[1]}, "R2", "header",
                    64'({out_phy_id, out_link_active, out_gap_count, out_speed, out_contender,
                         out_power_class, out_init_reset}),
                    64'({m_first[29:24], m_first[22], m_first[21:16], m_first[15:14], m_first[11],
                         m_first[10:8], m_first[1]}));
                chk(int'(out_quad_count) == m_cnt, "R3", "quad_count", 64'(out_quad_count), 64'(m_cnt));
                chk(out_port_codes == m_ports, "R9", "port_codes", 64'(out_port_codes), 64'(m_ports));
            end
            chk(fault_valid == m_fv, m_fv ? code_req(m_fc) : "R10", "fault_valid",
                64'(fault_valid), 64'(m_fv));
            if (m_fv && fault_valid)
                chk(int'(fault_code) == m_fc, code_req(m_fc), "fault_code", 64'(fault_code), 64'(m_fc));
        end
    end

    task automatic send(input logic [31:0] d, input logic l);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; in_quad = d; in_last = l;
        forever begin
            #1 ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] qf(input logic [5:0] phy, input logic lk, input logic [5:0] gap,
                                       input logic [1:0] sp, input logic con, input logic [2:0] pw,
                                       input logic ir, input logic [5:0] pt, input logic more);
        return {2'b10, phy, 1'b0, lk, gap, sp, 2'b00, con, pw, pt, ir, more};
    endfunction

    function automatic logic [31:0] qc(input logic [5:0] phy, input logic [2:0] sn, input logic ext,
                                       input logic [15:0] pt, input logic more);
        return {2'b10, phy, ext, sn, 2'b00, pt, 1'b0, more};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        // R1: reset state
        chk(out_valid == 0, "R1", "out_valid", 64'(out_valid), 0);
        chk(fault_valid == 0, "R1", "fault_valid", 64'(fault_valid), 0);
        chk(in_ready == 1, "R1", "in_ready", 64'(in_ready), 1);

        scen = "R2";
        send(qf(6'h2a, 1, 6'h3f, 2'd2, 1, 3'd5, 1, 6'b111001, 0), 1);
        send(qf(6'h15, 0, 6'h01, 2'd1, 0, 3'd2, 0, 6'b000110, 0), 1);
        idle(2);

        scen = "R3";
        send(qf(6'h03, 1, 6'h0a, 2'd3, 0, 3'd0, 0, 6'b101010, 1), 0);
        send(qc(6'h03, 3'd0, 1, 16'hc3a5, 0), 1);
        send(qf(6'h04, 0, 6'h22, 2'd0, 1, 3'd7, 1, 6'b011011, 1), 0);
        send(qc(6'h04, 3'd0, 1, 16'h1234, 1), 0);
        send(qc(6'h04, 3'd1, 1, 16'hfedc, 1), 0);
        send(qc(6'h04, 3'd2, 1, 16'h9b6d, 0), 1);
        idle(2);

        scen = "R9";
        send(qf(6'h05, 0, 6'h10, 2'd1, 0, 3'd1, 0, 6'b110110, 1), 0);
        send(qc(6'h05, 3'd0, 1, 16'hffff, 1), 0);
        send(qc(6'h05, 3'd1, 1, 16'h5555, 0), 0);
        send(qf(6'h06, 1, 6'h11, 2'd2, 1, 3'd3, 1, 6'b000000, 0), 1);
        idle(2);

        scen = "R4";
        send(qf(6'h07, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 1), 0);
        send(qc(6'h07, 3'd0, 0, 16'h0f0f, 0), 1);
        idle(2);

        scen = "R5";
        send(qf(6'h08, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 1), 0);
        send(qc(6'h08, 3'd0, 1, 16'h0f0f, 1), 0);
        send(qc(6'h08, 3'd2, 1, 16'h0f0f, 0), 0);
        scen = "R10";
        send(qf(6'h09, 1, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 0), 0);
        send(32'h0000_0001, 0);
        send(qf(6'h0a, 1, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 0), 1);
        send(qf(6'h0b, 1, 6'h06, 2'd1, 1, 3'd4, 0, 6'b100111, 0), 1);
        idle(2);

        scen = "R6";
        send(qf(6'h0c, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 1), 0);
        send(qc(6'h0c, 3'd0, 1, 16'h1111, 1), 0);
        send(qc(6'h0c, 3'd1, 1, 16'h2222, 1), 0);
        send(qc(6'h0c, 3'd2, 1, 16'h3333, 1), 0);
        send(qf(6'h0d, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 0), 1);
        idle(2);

        scen = "R7";
        send(qf(6'h0e, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 1), 1);
        send(qf(6'h0f, 1, 6'h2c, 2'd3, 1, 3'd6, 1, 6'b111111, 0), 1);
        send(qf(6'h10, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 1), 0);
        send(qc(6'h10, 3'd0, 1, 16'h4444, 1), 1);
        idle(2);

        scen = "R8";
        send(qf(6'h11, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 0) & 32'h3fff_ffff, 1);
        send(qf(6'h12, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 0) | 32'h4000_0000, 1);
        idle(2);

        scen = "R12";
        send(qf(6'h13, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 1), 0);
        send(qc(6'h13, 3'd5, 0, 16'h0000, 1) & 32'h3fff_ffff, 1);
        send(qf(6'h14, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 1), 0);
        send(qc(6'h14, 3'd5, 0, 16'h0000, 0), 1);
        send(qf(6'h15, 0, 6'h05, 2'd0, 0, 3'd0, 0, 6'b010101, 1), 0);
        send(qc(6'h15, 3'd0, 1, 16'h0000, 1), 0);
        send(qc(6'h15, 3'd1, 1, 16'h0000, 1), 0);
        send(qc(6'h15, 3'd2, 1, 16'h0000, 1), 1);
        idle(2);

        scen = "R11";
        stall_mode = 1'b1;
        for (int k = 0; k < 6; k++)
            send(qf(6'(k + 32), k[0], 6'(k * 7), 2'(k), k[1], 3'(k), k[0], 6'(k * 11), 0), k == 5);
        send(qf(6'h30, 1, 6'h12, 2'd2, 0, 3'd1, 1, 6'b100100, 1), 0);
        send(qc(6'h30, 3'd0, 1, 16'h8421, 0), 0);
        send(qf(6'h31, 0, 6'h13, 2'd1, 1, 3'd2, 0, 6'b011000, 0), 1);
        idle(12);
        stall_mode = 1'b0;
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule